// File: doc/BRIEF.md
# Accumulator Round and Saturate

This block turns a wide 40-bit accumulator value into a 16-bit signed register value. It sign-extends the accumulator, scales it by a signed shift code that can shift left or right, and rounds by adding one half of the 16-bit result LSB. It then clamps the value to the signed 16-bit range. Each conversion updates a saturation flag. The value that flag held before the conversion moves into a second, history flag, so a later step can see whether either of the last two conversions clipped.

A request is one cycle with `req_valid` high, with the accumulator and the shift code on the inputs. The result and both flags are registered and appear on the outputs one clock later. When no request is present, the outputs keep their values. The block does not store the accumulator and does not write any register.

Top module: `acc_round_sat`

## Requirements
- R1: While `rst_n` is low, `result`, `sat_flag` and `sat_prev` are zero.
- R2: A shift code of 0 to 3 (bit 2 clear) shifts the sign-extended accumulator left by that many places. The shift is done at a width of 44 bits, so no bits are lost.
- R3: A shift code of 4 to 7 (bit 2 set) is read as -4 to -1. It shifts the sign-extended accumulator arithmetically right by the magnitude of that value.
- R4: 0x8000 is added to the shifted value before the range check and before the result bits are taken.
- R5: If the rounded value is above 0x7FFFFFFF, `result` becomes 0x7FFF and `sat_flag` becomes 1.
- R6: If the rounded value is below -0x80000000, `result` becomes 0x8000 and `sat_flag` becomes 1.
- R7: If the rounded value is within range, `result` is bits 31:16 of the rounded value and `sat_flag` is cleared.
- R8: On every request, `sat_prev` takes the value `sat_flag` held before that request.
- R9: In a cycle without `req_valid`, `result`, `sat_flag` and `sat_prev` do not change.
- R10: The outputs for a request appear at the first clock edge after the cycle in which the request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| acc_in | input | 40 | Accumulator value, two's complement |
| shift_code | input | 3 | Signed shift amount, -4 to +3 |
| result | output | 16 | Rounded and saturated value |
| sat_flag | output | 1 | Set when the last conversion saturated |
| sat_prev | output | 1 | Value of `sat_flag` before the last conversion |

## Verification
The assertions check on every cycle that the outputs hold when there is no request and that the history flag copies the earlier saturation flag. They also check that a set saturation flag always comes with one of the two clamp codes, and that a zero accumulator gives a zero, unsaturated result. Only the bench scenarios can show the arithmetic itself: the shift direction and amount, the round-half boundary just below each limit, and the exact clamp decisions. The bench compares these against an independent model, using directed edge values and seeded random values.

// File: rtl/acc_round_sat.sv
module acc_round_sat #(
  parameter int ACC_W = 40,
  parameter int OUT_W = 16,
  parameter int SH_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [SH_W-1:0]  shift_code,
  output logic [OUT_W-1:0] result,
  output logic             sat_flag,
  output logic             sat_prev
);
  localparam int GUARD  = 1 << (SH_W - 1);
  localparam int WIDE_W = ACC_W + GUARD;
  localparam logic signed [WIDE_W-1:0] RND    = WIDE_W'(1) << (OUT_W - 1);
  localparam logic signed [WIDE_W-1:0] HI_LIM = (WIDE_W'(1) << (2*OUT_W - 1)) - WIDE_W'(1);
  localparam logic signed [WIDE_W-1:0] LO_LIM = -(WIDE_W'(1) << (2*OUT_W - 1));
  localparam logic [OUT_W-1:0] MAX_VAL = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_VAL = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [WIDE_W-1:0] acc_ext, shifted, rounded;
  logic [SH_W-1:0]  r_mag;
  logic             is_right, over, under, sat_nxt;
  logic [OUT_W-1:0] res_nxt;

  assign acc_ext  = {{GUARD{acc_in[ACC_W-1]}}, acc_in};
  assign is_right = shift_code[SH_W-1];
  assign r_mag    = ~shift_code + SH_W'(1);
  assign shifted  = is_right ? (acc_ext >>> r_mag) : (acc_ext <<< shift_code);
  assign rounded  = shifted + RND;
  assign over     = rounded > HI_LIM;
  assign under    = rounded < LO_LIM;
  assign sat_nxt  = over | under;
  assign res_nxt  = over  ? MAX_VAL :
                    under ? MIN_VAL :
                    rounded[2*OUT_W-1:OUT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      sat_flag <= 1'b0;
      sat_prev <= 1'b0;
    end else if (req_valid) begin
      result   <= res_nxt;
      sat_prev <= sat_flag;
      sat_flag <= sat_nxt;
    end
  end
endmodule

// File: rtl/acc_round_sat_chk.sv
module acc_round_sat_chk #(
  parameter int ACC_W = 40,
  parameter int OUT_W = 16,
  parameter int SH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [ACC_W-1:0] acc_in,
  input logic [SH_W-1:0]  shift_code,
  input logic [OUT_W-1:0] result,
  input logic             sat_flag,
  input logic             sat_prev
);
  localparam logic [OUT_W-1:0] MAX_VAL = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_VAL = {1'b1, {(OUT_W-1){1'b0}}};

  a_r1_reset_zero: assert property (@(posedge clk)
    (!rst_n && !req_valid) |=> (result == '0 && !sat_flag && !sat_prev));

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(result) && $stable(sat_flag) && $stable(sat_prev)));

  a_r8_history_copy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (sat_prev == $past(sat_flag)));

  a_r5_clamp_code: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |-> (result == MAX_VAL || result == MIN_VAL));

  a_r7_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_in == '0) |=> (result == '0 && !sat_flag));
endmodule

bind acc_round_sat acc_round_sat_chk chk_i (.*);

// File: tb/acc_round_sat_tb_top.sv
module acc_round_sat_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [39:0] acc_in = '0;
  logic [2:0]  shift_code = '0;
  logic [15:0] result;
  logic        sat_flag, sat_prev;

  int n_chk = 0, n_fail = 0;
  logic exp_flag = 1'b0;

  always #4 clk = ~clk;

  acc_round_sat dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .acc_in(acc_in), .shift_code(shift_code), .result(result),
    .sat_flag(sat_flag), .sat_prev(sat_prev));

  function automatic logic [16:0] model(input logic [39:0] a, input logic [2:0] c);
    longint v, r;
    int s;
    v = longint'($signed(a));
    s = c[2] ? int'(c) - 8 : int'(c);
    if (s >= 0) v = v <<< s; else v = v >>> (-s);
    r = v + 64'sd32768;
    if (r > 64'sh7FFFFFFF) return {1'b1, 16'h7FFF};
    if (r < -64'sh80000000) return {1'b1, 16'h8000};
    return {1'b0, r[31:16]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_req(input string req, input logic [39:0] a, input logic [2:0] c);
    logic [16:0] e;
    e = model(a, c);
    @(negedge clk);
    acc_in = a; shift_code = c; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " result"}, {16'h0, result}, {16'h0, e[15:0]});
    check({req, " flag"}, {31'h0, sat_flag}, {31'h0, e[16]});
    check("R8 history", {31'h0, sat_prev}, {31'h0, exp_flag});
    exp_flag = e[16];
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] hold_r;
    logic        hold_f, hold_p;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check("R1 reset result", {16'h0, result}, 32'h0);
    check("R1 reset flags", {30'h0, sat_flag, sat_prev}, 32'h0);
    rst_n = 1'b1;
    // R10: one cycle latency is what do_req samples at
    do_req("R7 zero", 40'h0, 3'd0);
    do_req("R4 round below limit", 40'h00_7FFF_7FFF, 3'd0);
    do_req("R5 round over limit", 40'h00_7FFF_8000, 3'd0);
    do_req("R8 second sat", 40'h7F_FFFF_FFFF, 3'd3);
    do_req("R4 round at low limit", 40'hFF_7FFF_8000, 3'd0);
    do_req("R6 below low limit", 40'hFF_7FFF_7FFF, 3'd0);
    do_req("R6 most negative", 40'h80_0000_0000, 3'd4);
    do_req("R2 left by 3", 40'h00_0123_4567, 3'd3);
    do_req("R2 left by 1", 40'hFF_F234_5678, 3'd1);
    do_req("R3 right by 4", 40'h07_1234_5678, 3'd4);
    do_req("R3 right by 1", 40'hFF_0000_0000, 3'd7);
    do_req("R3 right by 2", 40'h01_FFFF_0000, 3'd6);
    hold_r = result; hold_f = sat_flag; hold_p = sat_prev;
    @(negedge clk);
    acc_in = 40'h7F_FFFF_FFFF; shift_code = 3'd3;
    repeat (4) @(negedge clk);
    check("R9 hold", {14'h0, result, hold_f, hold_p}, {14'h0, hold_r, sat_flag, sat_prev});
    check("R9 hold result", {16'h0, result}, {16'h0, hold_r});
    for (int i = 0; i < 400; i++) begin
      logic [39:0] a;
      a = {$urandom(), $urandom()};
      if (i % 3 == 0) a = {{9{a[31]}}, a[30:0]};
      do_req("R2/R3/R7 random", a, 3'($urandom()));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule